// File: doc/BRIEF.md
# LCD Segment Output Polarity Driver

This block turns a latched display image into the logic-level drive bits for a row of LCD segment pins. The image holds two banks of `NUM_SEG` bits each. A segment that is lit must swing opposite to the common electrode, and a dark segment must follow it. The block therefore XORs the chosen image bit with the current common phase. In static mode only the low bank is shown. In half-duty dynamic mode, the bank that is shown follows whichever common line is in its select interval.

Two test pins override the image. One forces every segment lit and the other forces every segment dark. The force-lit pin wins when both are high. Neither pin changes the stored image, so releasing it brings back the earlier picture at once. If the common phase input is held at a constant level, the block acts as a plain output expander whose outputs are the data bits, either true or inverted.

All outputs are registered on the system clock. Every segment therefore changes on the same edge, one cycle after the inputs that cause the change.

Top module: `seg_polarity_drv`

## Requirements
- R1: While `rst_n` is low, `seg_drive` is all zeros.
- R2: Each `seg_drive` bit is registered. It reflects the inputs sampled at the previous rising clock edge, and all bits update on the same edge.
- R3: A lit segment drives the inverse of `com_phase`, and a dark segment drives the value of `com_phase`. Image bit value 1 means lit and 0 means dark.
- R4: When `dyn_mode` = 0 (static), segment n (0-based) uses `image[n]`. The upper bank `image[2*NUM_SEG-1:NUM_SEG]` and the `bank_b_sel` input have no effect on the output.
- R5: When `dyn_mode` = 1 and `bank_b_sel` = 0 (common A selected), segment n uses `image[n]`, and the upper bank has no effect.
- R6: When `dyn_mode` = 1 and `bank_b_sel` = 1 (common B selected), segment n uses `image[NUM_SEG+n]`, and the lower bank has no effect.
- R7: When `force_lit` = 1, every segment is lit, whatever the image, the mode and the bank select.
- R8: When `force_dark` = 1 and `force_lit` = 0, every segment is dark.
- R9: When `force_lit` = 1, `force_dark` has no effect.
- R10: When a force input is released with the image unchanged, the output returns to the image-derived value on the next edge, and no reload is needed.
- R11: If `com_phase` is held at 0, the outputs equal the selected data bits. If it is held at 1, the outputs are those bits inverted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| image | input | 2*NUM_SEG | Latched image. The low half is bank A and the high half is bank B |
| com_phase | input | 1 | Current level of the common waveform |
| bank_b_sel | input | 1 | 1 while common B is in its select interval |
| dyn_mode | input | 1 | 1 = half-duty dynamic, 0 = static |
| force_lit | input | 1 | Test input that forces all segments lit |
| force_dark | input | 1 | Test input that forces all segments dark |
| seg_drive | output | NUM_SEG | Registered segment drive bits |

## Verification
The bench uses a narrow instance and sweeps every image value against every combination of mode, bank select, common phase and the two force pins. Each output is compared with an arithmetic model, one cycle after the inputs are applied. This catches a bank mux that ignores the mode and so leaks bank B in static mode. It also catches a force priority that is the wrong way round, where dark wins over lit, and a polarity that is inverted or left out of the forced values. Separate sequences check three more things: that releasing a force restores the prior picture without touching the image, that a held phase gives true or inverted expander outputs, and that the reset value is zero. A design with an extra pipeline stage or a missing register would fail the one-cycle sampling in every check.

// File: rtl/segdrv_pkg.sv
package segdrv_pkg;

  // Override state decoded from the two test pins.
  typedef enum logic [1:0] {
    OVR_NONE = 2'd0,
    OVR_LIT  = 2'd1,
    OVR_DARK = 2'd2
  } ovr_e;

  // Decode the test pins. The force-lit pin has priority.
  function automatic ovr_e decode_ovr(input logic lit_pin, input logic dark_pin);
    ovr_e r;
    if (lit_pin)       r = OVR_LIT;
    else if (dark_pin) r = OVR_DARK;
    else               r = OVR_NONE;
    return r;
  endfunction

endpackage

// File: rtl/seg_bank_mux.sv
module seg_bank_mux #(
  parameter int NUM_SEG = 80,
  localparam int IMG_W  = 2 * NUM_SEG
) (
  input  logic [IMG_W-1:0]   image,
  input  logic               dyn_mode,
  input  logic               bank_b_sel,
  output logic [NUM_SEG-1:0] pixel
);

  // Bank B is shown only in dynamic mode while common B is selected.
  logic use_b;
  assign use_b = dyn_mode & bank_b_sel;

  for (genvar n = 0; n < NUM_SEG; n++) begin : g_bit
    assign pixel[n] = use_b ? image[NUM_SEG + n] : image[n];
  end

endmodule

// File: rtl/seg_test_override.sv
module seg_test_override
  import segdrv_pkg::*;
#(
  parameter int NUM_SEG = 80
) (
  input  logic [NUM_SEG-1:0] pixel,
  input  logic               force_lit,
  input  logic               force_dark,
  output logic [NUM_SEG-1:0] lit
);

  ovr_e ovr;

  always_comb begin
    ovr = decode_ovr(force_lit, force_dark);
    unique case (ovr)
      OVR_LIT:  lit = '1;
      OVR_DARK: lit = '0;
      default:  lit = pixel;
    endcase
  end

endmodule

// File: rtl/seg_phase_xor.sv
module seg_phase_xor #(
  parameter int NUM_SEG = 80
) (
  input  logic [NUM_SEG-1:0] lit,
  input  logic               com_phase,
  output logic [NUM_SEG-1:0] drive
);

  // A lit segment is driven opposite to the common line; a dark one follows it.
  for (genvar n = 0; n < NUM_SEG; n++) begin : g_bit
    assign drive[n] = lit[n] ^ com_phase;
  end

endmodule

// File: rtl/seg_polarity_drv.sv
module seg_polarity_drv #(
  parameter int NUM_SEG = 80,
  localparam int IMG_W  = 2 * NUM_SEG
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IMG_W-1:0]   image,
  input  logic               com_phase,
  input  logic               bank_b_sel,
  input  logic               dyn_mode,
  input  logic               force_lit,
  input  logic               force_dark,
  output logic [NUM_SEG-1:0] seg_drive
);

  logic [NUM_SEG-1:0] pixel;
  logic [NUM_SEG-1:0] lit;
  logic [NUM_SEG-1:0] drive_nxt;
  logic [NUM_SEG-1:0] drive_q;
  logic               upd_en;

  seg_bank_mux #(.NUM_SEG(NUM_SEG)) u_mux (
    .image      (image),
    .dyn_mode   (dyn_mode),
    .bank_b_sel (bank_b_sel),
    .pixel      (pixel)
  );

  seg_test_override #(.NUM_SEG(NUM_SEG)) u_ovr (
    .pixel      (pixel),
    .force_lit  (force_lit),
    .force_dark (force_dark),
    .lit        (lit)
  );

  seg_phase_xor #(.NUM_SEG(NUM_SEG)) u_xor (
    .lit       (lit),
    .com_phase (com_phase),
    .drive     (drive_nxt)
  );

  // The output register loads on every cycle.
  assign upd_en = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      drive_q <= '0;
    else if (upd_en) drive_q <= drive_nxt;
  end

  assign seg_drive = drive_q;

endmodule

// File: rtl/seg_polarity_drv_chk.sv
module seg_polarity_drv_chk #(
  parameter int NUM_SEG = 80,
  localparam int IMG_W  = 2 * NUM_SEG
) (
  input logic               clk,
  input logic               rst_n,
  input logic [IMG_W-1:0]   image,
  input logic               com_phase,
  input logic               bank_b_sel,
  input logic               dyn_mode,
  input logic               force_lit,
  input logic               force_dark,
  input logic [NUM_SEG-1:0] seg_drive
);

  // R7
  force_lit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_lit |=> seg_drive == {NUM_SEG{~$past(com_phase)}});

  // R8
  force_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (force_dark && !force_lit) |=> seg_drive == {NUM_SEG{$past(com_phase)}});

  // R9
  lit_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (force_dark && force_lit) |=> seg_drive == {NUM_SEG{~$past(com_phase)}});

  // R4
  static_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dyn_mode && !force_lit && !force_dark) |=>
      seg_drive == ($past(image[NUM_SEG-1:0]) ^ {NUM_SEG{$past(com_phase)}}));

  // R6
  dyn_bank_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dyn_mode && bank_b_sel && !force_lit && !force_dark) |=>
      seg_drive == ($past(image[IMG_W-1:NUM_SEG]) ^ {NUM_SEG{$past(com_phase)}}));

  // R5
  dyn_bank_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dyn_mode && !bank_b_sel && !force_lit && !force_dark) |=>
      seg_drive == ($past(image[NUM_SEG-1:0]) ^ {NUM_SEG{$past(com_phase)}}));

endmodule

bind seg_polarity_drv seg_polarity_drv_chk #(.NUM_SEG(NUM_SEG)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .image      (image),
  .com_phase  (com_phase),
  .bank_b_sel (bank_b_sel),
  .dyn_mode   (dyn_mode),
  .force_lit  (force_lit),
  .force_dark (force_dark),
  .seg_drive  (seg_drive)
);

// File: tb/sim_seg_polarity_drv.sv
module sim_seg_polarity_drv;

  localparam int N  = 4;
  localparam int IW = 2 * N;

  logic          clk;
  logic          rst_n;
  logic [IW-1:0] image;
  logic          com_phase, bank_b_sel, dyn_mode, force_lit, force_dark;
  logic [N-1:0]  seg_drive;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  seg_polarity_drv #(.NUM_SEG(N)) u0 (
    .clk(clk), .rst_n(rst_n), .image(image), .com_phase(com_phase),
    .bank_b_sel(bank_b_sel), .dyn_mode(dyn_mode), .force_lit(force_lit),
    .force_dark(force_dark), .seg_drive(seg_drive)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Reference: lit/dark per requirement, then XOR with phase.
  function automatic logic [N-1:0] model(input logic [IW-1:0] img, input logic dm,
                                          input logic bs, input logic ph,
                                          input logic fl, input logic fd);
    logic [N-1:0] r;
    for (int n = 0; n < N; n++) begin
      logic b;
      if (fl)           b = 1'b1;
      else if (fd)      b = 1'b0;
      else if (dm & bs) b = img[N + n];
      else              b = img[n];
      r[n] = b ^ ph;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [N-1:0] exp);
    total++;
    if (seg_drive !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", req, seg_drive, exp);
    end
  endtask

  task automatic drive(input logic [IW-1:0] img, input logic dm, input logic bs,
                       input logic ph, input logic fl, input logic fd);
    @(negedge clk);
    image = img; dyn_mode = dm; bank_b_sel = bs;
    com_phase = ph; force_lit = fl; force_dark = fd;
    @(negedge clk);
  endtask

  function automatic string req_of(input logic dm, input logic bs,
                                   input logic fl, input logic fd);
    if (fl && fd) return "R9";
    if (fl)       return "R7";
    if (fd)       return "R8";
    if (!dm)      return "R4";
    if (!bs)      return "R5";
    return "R6";
  endfunction

  initial begin
    rst_n = 1'b0; image = '0; com_phase = 0; bank_b_sel = 0;
    dyn_mode = 0; force_lit = 0; force_dark = 0;
    image = 8'hA5; com_phase = 1;
    #7;
    @(negedge clk);
    check("R1", '0);
    rst_n = 1'b1;

    // Exhaustive sweep; R2 timing and R3 polarity are checked by every vector.
    for (int c = 0; c < 32; c++) begin
      for (int v = 0; v < (1 << IW); v++) begin
        logic dm, bs, ph, fl, fd;
        {dm, bs, ph, fl, fd} = c[4:0];
        drive(v[IW-1:0], dm, bs, ph, fl, fd);
        check(req_of(dm, bs, fl, fd), model(v[IW-1:0], dm, bs, ph, fl, fd));
      end
    end

    // R3: polarity of the lit and dark segments in one image.
    drive(8'h05, 0, 0, 0, 0, 0);
    check("R3", 4'b0101);
    drive(8'h05, 0, 0, 1, 0, 0);
    check("R3", 4'b1010);

    // R10: release of each force pin restores the picture with the image unchanged.
    drive(8'h3C, 1, 1, 0, 0, 0);
    check("R10", 4'b0011);
    drive(8'h3C, 1, 1, 0, 1, 0);
    check("R10", 4'b1111);
    drive(8'h3C, 1, 1, 0, 0, 0);
    check("R10", 4'b0011);
    drive(8'h3C, 1, 1, 0, 0, 1);
    check("R10", 4'b0000);
    drive(8'h3C, 1, 1, 0, 0, 0);
    check("R10", 4'b0011);

    // R11: expander use with the phase held.
    drive(8'hF9, 0, 0, 0, 0, 0);
    check("R11", 4'b1001);
    drive(8'hF9, 0, 0, 1, 0, 0);
    check("R11", 4'b0110);

    // R2: the output holds the old value until the edge, then all bits change together.
    @(negedge clk);
    com_phase = 0;
    @(posedge clk);
    #1;
    check("R2", 4'b1001);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule